// File: doc/BRIEF.md
# Striped-Storage All-Pairs Box Overlap Engine

This block takes a list of axis-aligned bounding boxes and reports every pair of them that intersects. Each box carries six IEEE 754 single-precision bounds: a minimum and a maximum on each of x, y and z. Boxes arrive one per cycle and are numbered in arrival order. They are spread round-robin over `M` storage groups, so each group holds one column of rows `M` wide, and no box is stored twice. A `go` pulse starts the pairwise sweep. Each overlapping pair leaves through a ready/valid output queue as (lower index, higher index).

During the sweep, the first port of every group reads the same row. The second ports read partner rows on a staggered schedule. Each group's second port moves one row further on in turn. A per-lane selector, which starts at lane+1 and advances by one per cycle modulo `M`, then routes a different partner to each lane. Lane `k` of row base `b` therefore meets object `b+k+1+s` on sweep step `s`. Every unordered pair is tested exactly once, and up to `M` tests finish per cycle. Tests whose partner index is at or beyond the box count are dropped. When the output queue lacks room for the results still in flight, the sweep pauses.

Top module: `aabb_allpairs`

## Requirements
- R1: The k-th box accepted since the last `go` gets index k. It is stored in group k mod M at row k/M. The bounds are packed in `ld_box` as x-min [31:0], x-max [63:32], y-min [95:64], y-max [127:96], z-min [159:128], z-max [191:160].
- R2: Every intersecting pair i<j<n is reported exactly once, with `pair_lo`=i and `pair_hi`=j.
- R3: Two boxes intersect when, on all three axes, each one's minimum is at most the other's maximum. Touching faces count as intersecting. A pair that is separated on any axis is never reported.
- R4: Bounds are ordered as single-precision numbers. Negative values sort below positive ones, and -0.0 equals +0.0. NaN bounds are not supported.
- R5: No reported index reaches n, whether or not n is a multiple of M. A full load of n = M*DEPTH boxes is handled.
- R6: A `go` with fewer than two boxes loaded completes with a `done` pulse and reports no pairs.
- R7: While `pair_valid` is high and `pair_ready` is low, `pair_lo` and `pair_hi` hold their values. No pair is lost, and the queue never exceeds its depth, because the sweep pauses.
- R8: `ld_valid` and `go` have no effect while `busy` is high. A `go` in the same cycle as `ld_valid` takes precedence, and that box is not loaded.
- R9: After reset, `busy`, `done` and `pair_valid` are low. `done` is a one-cycle pulse in the last busy cycle, once the final result has entered the output queue. The next load then starts again at index 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ld_valid | input | 1 | Load the box on `ld_box` at the next index |
| ld_box | input | 192 | Six single-precision bounds, layout as in R1 |
| go | input | 1 | Start the sweep over the boxes loaded so far |
| busy | output | 1 | Sweep in progress; loads and `go` are ignored |
| done | output | 1 | One-cycle pulse when the sweep has finished |
| pair_valid | output | 1 | An overlapping pair is available |
| pair_ready | input | 1 | Consumer accepts the presented pair |
| pair_lo | output | IW | Lower index of the pair (IW = log2 M + log2 DEPTH + 1) |
| pair_hi | output | IW | Higher index of the pair |

## Verification
The bench runs two engines, one with four groups and one with two, on the same stimulus. It compares their full pair matrices with an all-pairs reference that works on real numbers. Random dense box sets at n = 5, 7, 13, 17, 31 and 32 mostly end in a partial row for one or both widths. This exposes schedule errors such as missed, repeated or out-of-range pairs. Hand-built sets separate the inclusive comparison (shared faces, a zero-width box) from a strict one, and signed-zero and all-negative boxes separate true float ordering from raw bit ordering. A random-backpressure run, a run poked with loads and `go` while busy, and the degenerate counts 0, 1 and 2 probe flow control, input gating and the sweep's end condition.

// File: rtl/aabb_pkg.sv
`timescale 1ns/1ps
package aabb_pkg;
  localparam int FW    = 32;
  localparam int BOX_W = 6 * FW;

  // x-min sits in the low word, z-max in the high word
  typedef struct packed {
    logic [FW-1:0] zmax;
    logic [FW-1:0] zmin;
    logic [FW-1:0] ymax;
    logic [FW-1:0] ymin;
    logic [FW-1:0] xmax;
    logic [FW-1:0] xmin;
  } box_t;

  // map a single-precision value onto an unsigned key with the same order;
  // both zero encodings collapse onto one key
  function automatic logic [FW-1:0] order_key(input logic [FW-1:0] f);
    if (f[FW-2:0] == '0) return {1'b1, {(FW-1){1'b0}}};
    else if (f[FW-1])    return ~f;
    else                 return {1'b1, f[FW-2:0]};
  endfunction

  function automatic logic f_le(input logic [FW-1:0] a, input logic [FW-1:0] b);
    return order_key(a) <= order_key(b);
  endfunction

  // inclusive overlap on all three axes
  function automatic logic boxes_touch(input box_t a, input box_t b);
    return f_le(b.xmin, a.xmax) && f_le(a.xmin, b.xmax) &&
           f_le(b.ymin, a.ymax) && f_le(a.ymin, b.ymax) &&
           f_le(b.zmin, a.zmax) && f_le(a.zmin, b.zmax);
  endfunction
endpackage

// File: rtl/aabb_bank.sv
`timescale 1ns/1ps
// One storage group: six bound fields kept side by side, one write/read
// port used for loading and row reads, one read-only partner port.
module aabb_bank
  import aabb_pkg::*;
#(
  parameter int DEPTH = 8,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          a_we,
  input  logic [AW-1:0] a_addr,
  input  box_t          a_wdata,
  output box_t          a_rdata,
  input  logic [AW-1:0] b_addr,
  output box_t          b_rdata
);
  box_t mem [DEPTH];

  always_ff @(posedge clk) begin
    if (a_we) mem[a_addr] <= a_wdata;
    a_rdata <= mem[a_addr];
    b_rdata <= mem[b_addr];
  end
endmodule

// File: rtl/aabb_pair_seq.sv
`timescale 1ns/1ps
// Sweep sequencer: row base advances by M, step s counts partner offsets.
// Lane k of the current row meets object base+k+1+s.
module aabb_pair_seq #(
  parameter int M     = 4,
  parameter int DEPTH = 8,
  localparam int MW = $clog2(M),
  localparam int AW = $clog2(DEPTH),
  localparam int IW = MW + AW + 1
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  start,
  input  logic [IW-1:0]         n_obj,
  input  logic                  room,
  output logic                  issue,
  output logic                  running,
  output logic [AW-1:0]         a_row,
  output logic [M-1:0][AW-1:0]  b_row,
  output logic [IW-1:0]         abase,
  output logic [IW-1:0]         step
);
  localparam int XW = IW + 2;

  logic          run_q;
  logic [IW-1:0] base_q, step_q, cnt_q;
  logic          row_end, last_row;

  assign issue    = run_q && room;
  assign running  = run_q;
  assign abase    = base_q;
  assign step     = step_q;
  assign a_row    = AW'(base_q >> MW);
  // the last partner of lane 0 is object n-1
  assign row_end  = (XW'(base_q) + XW'(step_q) + XW'(2)) == XW'(cnt_q);
  // no later row holds an object with a higher partner
  assign last_row = (XW'(base_q) + XW'(M) + XW'(2)) > XW'(cnt_q);

  // group g's partner row moves on once the rotation reaches g
  for (genvar g = 0; g < M; g++) begin : g_brow
    assign b_row[g] = AW'((XW'(base_q) + XW'(step_q) + XW'(M - g)) >> MW);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run_q  <= 1'b0;
      base_q <= '0;
      step_q <= '0;
      cnt_q  <= '0;
    end else if (!run_q) begin
      if (start && (n_obj >= IW'(2))) begin
        run_q  <= 1'b1;
        cnt_q  <= n_obj;
        base_q <= '0;
        step_q <= '0;
      end
    end else if (issue) begin
      if (row_end) begin
        step_q <= '0;
        if (last_row) run_q  <= 1'b0;
        else          base_q <= base_q + IW'(M);
      end else begin
        step_q <= step_q + IW'(1);
      end
    end
  end
endmodule

// File: rtl/aabb_pair_fifo.sv
`timescale 1ns/1ps
// Output queue taking up to LANES pairs per cycle, packed in lane order,
// and handing out one pair per cycle.
module aabb_pair_fifo #(
  parameter int LANES = 4,
  parameter int DEPTH = 16,
  parameter int IW    = 6,
  localparam int PW = $clog2(DEPTH),
  localparam int CW = PW + 1
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [LANES-1:0]           wr_mask,
  input  logic [LANES-1:0][IW-1:0]   wr_lo,
  input  logic [LANES-1:0][IW-1:0]   wr_hi,
  input  logic                       rd_en,
  output logic                       rd_valid,
  output logic [IW-1:0]              rd_lo,
  output logic [IW-1:0]              rd_hi,
  output logic [CW-1:0]              level
);
  logic [2*IW-1:0]           mem [DEPTH];
  logic [PW-1:0]             rp, wp;
  logic [CW-1:0]             cnt, nwr;
  logic [LANES-1:0][PW-1:0]  slot;
  logic                      pop;

  always_comb begin
    nwr = '0;
    for (int k = 0; k < LANES; k++) begin
      slot[k] = wp + PW'(nwr);
      nwr     = nwr + CW'(wr_mask[k]);
    end
  end

  assign pop      = rd_en && (cnt != '0);
  assign rd_valid = (cnt != '0);
  assign {rd_lo, rd_hi} = mem[rp];
  assign level    = cnt;

  always_ff @(posedge clk) begin
    for (int k = 0; k < LANES; k++)
      if (wr_mask[k]) mem[slot[k]] <= {wr_lo[k], wr_hi[k]};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rp  <= '0;
      wp  <= '0;
      cnt <= '0;
    end else begin
      rp  <= rp + PW'(pop);
      wp  <= wp + PW'(nwr);
      cnt <= cnt + nwr - CW'(pop);
    end
  end
endmodule

// File: rtl/aabb_allpairs.sv
`timescale 1ns/1ps
module aabb_allpairs
  import aabb_pkg::*;
#(
  parameter int M          = 4,
  parameter int DEPTH      = 8,
  parameter int FIFO_DEPTH = 16,
  localparam int MW = $clog2(M),
  localparam int AW = $clog2(DEPTH),
  localparam int IW = MW + AW + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ld_valid,
  input  logic [BOX_W-1:0] ld_box,
  input  logic             go,
  output logic             busy,
  output logic             done,
  output logic             pair_valid,
  input  logic             pair_ready,
  output logic [IW-1:0]    pair_lo,
  output logic [IW-1:0]    pair_hi
);
  localparam int XW  = IW + 2;
  localparam int CW  = $clog2(FIFO_DEPTH) + 1;
  localparam int CAP = M * DEPTH;

  logic                 busy_q;
  logic [IW-1:0]        ld_idx, n_q;
  logic                 ld_fire, go_fire;
  logic                 issue, seq_run, room;
  logic [AW-1:0]        a_row;
  logic [M-1:0][AW-1:0] b_row;
  logic [IW-1:0]        abase, step;
  logic                 v1, v2;
  logic [IW-1:0]        abase1, step1;
  logic [CW-1:0]        fifo_level;
  box_t [M-1:0]         rd_a, rd_b;
  logic [M-1:0][MW-1:0] sel;
  logic [M-1:0]         hit1, hit2;
  logic [M-1:0][IW-1:0] lo1, hi1, lo2, hi2;

  assign go_fire = go && !busy_q;
  assign ld_fire = ld_valid && !go && !busy_q && (ld_idx < IW'(CAP));
  // reserve space for this issue and the two stages already in flight
  assign room    = (int'(fifo_level) + M * (int'(v1) + int'(v2) + 1)) <= FIFO_DEPTH;
  assign busy    = busy_q;
  assign done    = busy_q && !seq_run && !v1 && !v2;

  aabb_pair_seq #(.M(M), .DEPTH(DEPTH)) u_seq (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (go_fire),
    .n_obj   (ld_idx),
    .room    (room),
    .issue   (issue),
    .running (seq_run),
    .a_row   (a_row),
    .b_row   (b_row),
    .abase   (abase),
    .step    (step)
  );

  for (genvar g = 0; g < M; g++) begin : g_bank
    logic wr_g;
    assign wr_g = ld_fire && (ld_idx[MW-1:0] == MW'(g));
    aabb_bank #(.DEPTH(DEPTH)) u_bank (
      .clk     (clk),
      .a_we    (wr_g),
      .a_addr  (busy_q ? a_row : ld_idx[MW +: AW]),
      .a_wdata (box_t'(ld_box)),
      .a_rdata (rd_a[g]),
      .b_addr  (b_row[g]),
      .b_rdata (rd_b[g])
    );
  end

  // rotating crossbar: lane k takes the partner port of group (k+1+s) mod M
  for (genvar k = 0; k < M; k++) begin : g_lane
    logic [XW-1:0] ia, ib;
    assign sel[k]  = MW'(step1 + IW'(k + 1));
    assign ia      = XW'(abase1) + XW'(k);
    assign ib      = ia + XW'(step1) + XW'(1);
    assign hit1[k] = v1 && boxes_touch(rd_a[k], rd_b[sel[k]]) && (ib < XW'(n_q));
    assign lo1[k]  = IW'(ia);
    assign hi1[k]  = IW'(ib);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      ld_idx <= '0;
      n_q    <= '0;
      v1     <= 1'b0;
      v2     <= 1'b0;
      abase1 <= '0;
      step1  <= '0;
      hit2   <= '0;
      lo2    <= '0;
      hi2    <= '0;
    end else begin
      if (go_fire) begin
        busy_q <= 1'b1;
        n_q    <= ld_idx;
        ld_idx <= '0;
      end else begin
        if (done)    busy_q <= 1'b0;
        if (ld_fire) ld_idx <= ld_idx + IW'(1);
      end
      v1     <= issue;
      abase1 <= abase;
      step1  <= step;
      v2     <= v1;
      hit2   <= hit1;
      lo2    <= lo1;
      hi2    <= hi1;
    end
  end

  aabb_pair_fifo #(.LANES(M), .DEPTH(FIFO_DEPTH), .IW(IW)) u_fifo (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_mask  (hit2),
    .wr_lo    (lo2),
    .wr_hi    (hi2),
    .rd_en    (pair_ready),
    .rd_valid (pair_valid),
    .rd_lo    (pair_lo),
    .rd_hi    (pair_hi),
    .level    (fifo_level)
  );
endmodule

// File: rtl/aabb_allpairs_chk.sv
`timescale 1ns/1ps
module aabb_allpairs_chk #(
  parameter int M          = 4,
  parameter int DEPTH      = 8,
  parameter int FIFO_DEPTH = 16,
  localparam int MW = $clog2(M),
  localparam int AW = $clog2(DEPTH),
  localparam int IW = MW + AW + 1,
  localparam int CW = $clog2(FIFO_DEPTH) + 1
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 busy,
  input logic                 done,
  input logic                 pair_valid,
  input logic                 pair_ready,
  input logic [IW-1:0]        pair_lo,
  input logic [IW-1:0]        pair_hi,
  input logic [IW-1:0]        n_q,
  input logic [M-1:0]         hit2,
  input logic [M-1:0][IW-1:0] hi2,
  input logic [CW-1:0]        fifo_level
);
  p_order_r2: assert property (@(posedge clk) disable iff (!rst_n)
    pair_valid |-> (pair_lo < pair_hi));

  for (genvar k = 0; k < M; k++) begin : g_rng
    p_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
      hit2[k] |-> (hi2[k] < n_q));
  end

  p_no_overflow_r7: assert property (@(posedge clk) disable iff (!rst_n)
    int'(fifo_level) <= FIFO_DEPTH);

  p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (pair_valid && !pair_ready) |=> (pair_valid && $stable(pair_lo) && $stable(pair_hi)));

  p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_busy_fall_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> $past(done));
endmodule

bind aabb_allpairs aabb_allpairs_chk #(.M(M), .DEPTH(DEPTH), .FIFO_DEPTH(FIFO_DEPTH)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .busy       (busy),
  .done       (done),
  .pair_valid (pair_valid),
  .pair_ready (pair_ready),
  .pair_lo    (pair_lo),
  .pair_hi    (pair_hi),
  .n_q        (n_q),
  .hit2       (hit2),
  .hi2        (hi2),
  .fifo_level (fifo_level)
);

// File: tb/tb_aabb_allpairs.sv
`timescale 1ns/1ps
module tb_aabb_allpairs;
  localparam int NMAX = 32;

  logic clk = 1'b0, rst_n = 1'b0;
  always #10 clk = ~clk;

  logic         ld_valid = 1'b0, go = 1'b0, ready = 1'b1;
  logic [191:0] ld_box = '0;
  logic         busy_a, done_a, pv_a, busy_b, done_b, pv_b;
  logic [5:0]   lo_a, hi_a, lo_b, hi_b;

  int checks = 0, errors = 0;
  logic [31:0] bx [NMAX][6];
  int  seen_a [NMAX][NMAX];
  int  seen_b [NMAX][NMAX];
  bit  dseen_a, dseen_b, stall_en;
  int  hold_err;
  int unsigned rs = 32'h1234_5678;

  aabb_allpairs #(.M(4), .DEPTH(8), .FIFO_DEPTH(16)) dut (
    .clk(clk), .rst_n(rst_n), .ld_valid(ld_valid), .ld_box(ld_box), .go(go),
    .busy(busy_a), .done(done_a), .pair_valid(pv_a), .pair_ready(ready),
    .pair_lo(lo_a), .pair_hi(hi_a));

  aabb_allpairs #(.M(2), .DEPTH(16), .FIFO_DEPTH(8)) dut_m2 (
    .clk(clk), .rst_n(rst_n), .ld_valid(ld_valid), .ld_box(ld_box), .go(go),
    .busy(busy_b), .done(done_b), .pair_valid(pv_b), .pair_ready(ready),
    .pair_lo(lo_b), .pair_hi(hi_b));

  int unsigned bp = 32'hACE1;
  always @(posedge clk) begin
    bp    <= bp * 32'd1103515245 + 32'd12345;
    ready <= stall_en ? bp[17] : 1'b1;
  end

  bit pst_a, pst_b;
  logic [5:0] plo_a, phi_a, plo_b, phi_b;
  always @(negedge clk) if (rst_n) begin
    if (pst_a && !(pv_a && lo_a == plo_a && hi_a == phi_a)) hold_err++;
    if (pst_b && !(pv_b && lo_b == plo_b && hi_b == phi_b)) hold_err++;
    pst_a = pv_a && !ready; plo_a = lo_a; phi_a = hi_a;
    pst_b = pv_b && !ready; plo_b = lo_b; phi_b = hi_b;
    if (pv_a && ready && lo_a < NMAX && hi_a < NMAX) seen_a[lo_a][hi_a]++;
    if (pv_b && ready && lo_b < NMAX && hi_b < NMAX) seen_b[lo_b][hi_b]++;
    if (done_a) dseen_a = 1;
    if (done_b) dseen_b = 1;
  end

  function automatic logic [31:0] fb(input real v);
    return $shortrealtobits(v);
  endfunction

  function automatic bit ref_hit(input int i, input int j);
    for (int ax = 0; ax < 3; ax++) begin
      real amin = $bitstoshortreal(bx[i][2*ax]);
      real amax = $bitstoshortreal(bx[i][2*ax+1]);
      real bmin = $bitstoshortreal(bx[j][2*ax]);
      real bmax = $bitstoshortreal(bx[j][2*ax+1]);
      if (amax < bmin || bmax < amin) return 0;
    end
    return 1;
  endfunction

  task automatic set_axis(input int i, input int ax, input real mn, input real mx);
    bx[i][2*ax]   = fb(mn);
    bx[i][2*ax+1] = fb(mx);
  endtask

  task automatic rand_boxes(input int n);
    for (int i = 0; i < n; i++)
      for (int ax = 0; ax < 3; ax++) begin
        int lo, sz;
        rs = rs * 32'd1664525 + 32'd1013904223;
        lo = int'((rs >> 8) % 17) - 8;
        sz = int'((rs >> 20) % 7);
        set_axis(i, ax, lo * 0.5, (lo + sz) * 0.5);
      end
  endtask

  task automatic check(input bit ok, input string msg, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", msg, act, exp);
    end
  endtask

  task automatic check_pairs(input string tag, input int n);
    int bad_a = 0, bad_b = 0;
    for (int i = 0; i < NMAX; i++)
      for (int j = 0; j < NMAX; j++) begin
        int e = (i < j && j < n && ref_hit(i, j)) ? 1 : 0;
        if (seen_a[i][j] != e) begin
          if (bad_a == 0)
            $display("FAIL %s M=4 pair (%0d,%0d) actual %0d expected %0d", tag, i, j, seen_a[i][j], e);
          bad_a++;
        end
        if (seen_b[i][j] != e) begin
          if (bad_b == 0)
            $display("FAIL %s M=2 pair (%0d,%0d) actual %0d expected %0d", tag, i, j, seen_b[i][j], e);
          bad_b++;
        end
      end
    checks += 2;
    errors += (bad_a != 0) + (bad_b != 0);
  endtask

  task automatic run_frame(input string tag, input int n, input bit stall, input bit poke);
    for (int i = 0; i < NMAX; i++)
      for (int j = 0; j < NMAX; j++) begin seen_a[i][j] = 0; seen_b[i][j] = 0; end
    dseen_a = 0; dseen_b = 0; hold_err = 0;
    stall_en = stall;
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #1;
      ld_valid = 1'b1;
      ld_box   = {bx[i][5], bx[i][4], bx[i][3], bx[i][2], bx[i][1], bx[i][0]};
    end
    @(posedge clk); #1; ld_valid = 1'b0; go = 1'b1;
    @(posedge clk); #1; go = 1'b0;
    if (poke) begin
      // R8: junk load and a second go while both engines are busy
      repeat (3) @(posedge clk); #1;
      ld_valid = 1'b1; ld_box = '1; go = 1'b1;
      @(posedge clk); #1; ld_valid = 1'b0; go = 1'b0;
    end
    while (!(dseen_a && dseen_b)) @(negedge clk);
    stall_en = 1'b0;
    repeat (3) @(negedge clk);
    while (pv_a || pv_b) @(negedge clk);
    repeat (2) @(negedge clk);
    check_pairs(tag, n);
    if (stall) check(hold_err == 0, "R7 output held under backpressure", hold_err, 0);
    check(!busy_a && !busy_b, "R9 busy low after done", int'(busy_a) + int'(busy_b), 0);
  endtask

  initial begin
    #4_000_000;
    errors++;
    $display("FAIL watchdog expired actual 1 expected 0");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk); #1; rst_n = 1'b1;
    @(negedge clk);
    check(!busy_a && !done_a && !pv_a && !busy_b && !done_b && !pv_b,
          "R9 reset state quiet", int'(busy_a | done_a | pv_a | busy_b | done_b | pv_b), 0);

    // R6: empty and single-box frames
    run_frame("R6 n=0", 0, 0, 0);
    rand_boxes(1);
    run_frame("R6 n=1", 1, 0, 0);

    // R2 / R3 smallest sweep: one overlapping, one disjoint
    for (int ax = 0; ax < 3; ax++) begin set_axis(0, ax, 0.0, 2.0); set_axis(1, ax, 1.0, 3.0); end
    run_frame("R2 n=2 overlap", 2, 0, 0);
    set_axis(1, 1, 2.5, 3.0);
    run_frame("R3 n=2 separated on y", 2, 0, 0);

    // R3 touching faces and a zero-width box
    for (int i = 0; i < 4; i++)
      for (int ax = 1; ax < 3; ax++) set_axis(i, ax, 0.0, 1.0);
    set_axis(0, 0, 0.0, 1.0);
    set_axis(1, 0, 1.0, 2.0);
    set_axis(2, 0, 2.5, 3.0);
    set_axis(3, 0, 1.0, 1.0);
    run_frame("R3 touching faces inclusive", 4, 0, 0);

    // R4 signed zero and negative ordering
    for (int i = 0; i < 5; i++)
      for (int ax = 1; ax < 3; ax++) set_axis(i, ax, -4.0, -1.0);
    bx[0][0] = fb(-1.0); bx[0][1] = 32'h8000_0000;
    bx[1][0] = 32'h0000_0000; bx[1][1] = fb(2.0);
    set_axis(2, 0, 0.5, 1.0);
    set_axis(3, 0, -3.0, -2.0);
    set_axis(4, 0, -2.5, -1.5);
    run_frame("R4 signed zero and negatives", 5, 0, 0);

    // R1 R2 R5 random frames over partial and full rows
    rand_boxes(5);  run_frame("R1 R2 R5 n=5", 5, 0, 0);
    rand_boxes(7);  run_frame("R1 R2 R5 n=7", 7, 0, 0);
    rand_boxes(13); run_frame("R1 R2 R5 n=13", 13, 0, 0);
    rand_boxes(17); run_frame("R1 R2 R5 n=17", 17, 0, 0);
    rand_boxes(32); run_frame("R5 full capacity n=32", 32, 0, 0);

    // R7 random backpressure with dense overlaps
    for (int i = 0; i < 31; i++)
      for (int ax = 0; ax < 3; ax++) set_axis(i, ax, -1.0 * (i % 3), 1.0 + (i % 4));
    set_axis(30, 2, 9.0, 9.5);
    run_frame("R7 stalled output n=31", 31, 1, 0);
    rand_boxes(24); run_frame("R7 stalled random n=24", 24, 1, 0);

    // R8 loads and go while busy, then a clean follow-up frame
    rand_boxes(32); run_frame("R8 poked while busy", 32, 0, 1);
    rand_boxes(9);  run_frame("R8 next frame starts at index 0", 9, 0, 0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule